// File: doc/BRIEF.md
# Elapsed-Time Real-Time Clock with Alarm and Periodic Timer

This peripheral keeps a free-running 48-bit elapsed-time count that advances once per 32.768 kHz tick, qualified by the `tickEn` input. Bits 14:0 are the sub-second fraction and bits 47:15 are whole seconds. Software sees the count as three 16-bit words. A full time value is therefore `high<<17 | mid<<1 | low>>15` seconds. The words are not latched together, so software re-reads until two readouts agree.

A 48-bit alarm compare value uses the same layout as the count and raises the alarm interrupt when the count equals it. A 32-bit periodic down-counter reloads from a programmable value and raises the periodic interrupt once every reload-count ticks. For a rate f, software programs 32768/f. Both events are latched in a status register that sits in a second address window and is cleared by writing one. A zero compare value disables the alarm. A zero reload value disables the periodic timer.

Top module: `elapsed_rtc`

## Requirements
- R1: After reset every readable register reads 0x0000, and both `alarmIrq` and `periodIrq` are low.
- R2: Each cycle with `tickEn` high adds one to the 48-bit count. The carry ripples across all three words: low (window 0, 0x00), mid (0x02) and high (0x04).
- R3: A write to one time word loads that word on the next clock edge and leaves the other two words unchanged.
- R4: On a cycle where the compare value (0x08 low, 0x0A mid, 0x0C high) is nonzero and equals the count, status bit 0 and `alarmIrq` go high on the following clock edge.
- R5: A match that persists raises the alarm event only once. A new event needs the count to leave the compare value and then reach it again.
- R6: Each status bit, and the interrupt line driven from it, stays high until software clears it.
- R7: These registers read back through `rdData`, combinationally from `busSel`/`busAddr`:
  - window 0 at 0x10/0x12: the reload value, low and high halves;
  - window 0 at 0x14/0x16: the live periodic count;
  - window 1 at 0x1E: the status register, with bit 0 alarm and bit 1 periodic, and bits 3:2 as placeholders that always read 0.
  Any other offset reads 0.
- R8: Writing the status register clears exactly those status bits whose write-data bit is 1. Bits written as 0 are untouched.
- R9: A compare value of zero never raises the alarm event, even when the count is zero.
- R10: Writing either reload half restarts the counter from the new reload value R. The periodic event then occurs on the R-th following tick.
- R11: A periodic event sets status bit 1 and `periodIrq`, and reloads the counter with R in the same edge.
- R12: If an event and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R13: A reload value of zero holds the counter at zero and produces no periodic events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle 32.768 kHz tick qualifier |
| busSel | input | 1 | Window select: 0 timers, 1 status |
| busAddr | input | 5 | Byte offset inside the window |
| busWr | input | 1 | Write strobe |
| busWdata | input | 16 | Write data |
| rdData | output | 16 | Read data for the addressed register |
| alarmIrq | output | 1 | Alarm interrupt (status bit 0) |
| periodIrq | output | 1 | Periodic interrupt (status bit 1) |

## Verification
A corrupted count shows up on the time words in the readout right after the next tick. A lost carry shows as a word that fails to step when the word below it wraps. A wrong down-counter shows on the count readout one tick after the fault, and as a periodic interrupt that arrives early, late or never. A status bit that clears wrongly, refires during a held match, or loses a same-cycle race shows on the interrupt pins one edge later.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int DATA_W       = 16;
  localparam int ADDR_W       = 5;
  localparam int TIME_WORDS   = 3;
  localparam int RELOAD_WORDS = 2;
  localparam int STAT_W       = 4;

  typedef enum logic [2:0] {
    RD_ZERO, RD_TIME, RD_CMP, RD_RELOAD, RD_COUNT, RD_STAT
  } rdKind_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic [TIME_WORDS-1:0]   wrTime;
    logic [TIME_WORDS-1:0]   wrCmp;
    logic [RELOAD_WORDS-1:0] wrReload;
    logic                    clrStat;
    rdKind_e                 rdKind;
    logic [1:0]              rdIdx;
  } rtcCtrl_t;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int TIME_BASE   = 'h00,
  parameter int CMP_BASE    = 'h08,
  parameter int RELOAD_BASE = 'h10,
  parameter int COUNT_BASE  = 'h14,
  parameter int STAT_OFF    = 'h1E
) (
  input  logic              busSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output rtcCtrl_t          ctrl
);
  logic [TIME_WORDS-1:0]   hitTime, hitCmp;
  logic [RELOAD_WORDS-1:0] hitReload, hitCount;
  logic                    hitStat;

  for (genvar i = 0; i < TIME_WORDS; i++) begin : g_timeHit
    assign hitTime[i] = !busSel && (busAddr == ADDR_W'(TIME_BASE + 2*i));
    assign hitCmp[i]  = !busSel && (busAddr == ADDR_W'(CMP_BASE + 2*i));
  end
  for (genvar i = 0; i < RELOAD_WORDS; i++) begin : g_relHit
    assign hitReload[i] = !busSel && (busAddr == ADDR_W'(RELOAD_BASE + 2*i));
    assign hitCount[i]  = !busSel && (busAddr == ADDR_W'(COUNT_BASE + 2*i));
  end
  assign hitStat = busSel && (busAddr == ADDR_W'(STAT_OFF));

  always_comb begin
    ctrl          = '0;
    ctrl.wrTime   = busWr ? hitTime : '0;
    ctrl.wrCmp    = busWr ? hitCmp : '0;
    ctrl.wrReload = busWr ? hitReload : '0;
    ctrl.clrStat  = busWr && hitStat;
    ctrl.rdKind   = RD_ZERO;
    for (int i = 0; i < TIME_WORDS; i++) begin
      if (hitTime[i]) begin ctrl.rdKind = RD_TIME; ctrl.rdIdx = 2'(i); end
      if (hitCmp[i])  begin ctrl.rdKind = RD_CMP;  ctrl.rdIdx = 2'(i); end
    end
    for (int i = 0; i < RELOAD_WORDS; i++) begin
      if (hitReload[i]) begin ctrl.rdKind = RD_RELOAD; ctrl.rdIdx = 2'(i); end
      if (hitCount[i])  begin ctrl.rdKind = RD_COUNT;  ctrl.rdIdx = 2'(i); end
    end
    if (hitStat) ctrl.rdKind = RD_STAT;
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  rtcCtrl_t          ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq,
  output logic              periodIrq
);
  localparam int TIME_W   = DATA_W * TIME_WORDS;
  localparam int RELOAD_W = DATA_W * RELOAD_WORDS;

  logic [TIME_W-1:0]   timeQ, timeD, cmpQ, cmpD;
  logic [RELOAD_W-1:0] reloadQ, reloadD, cntQ, cntD;
  logic [1:0]          statQ, statD;
  logic                prevMatch, match, alarmEv, periodEv;

  always_comb begin
    timeD   = timeQ + TIME_W'(tickEn);
    cmpD    = cmpQ;
    reloadD = reloadQ;
    for (int i = 0; i < TIME_WORDS; i++) begin
      if (ctrl.wrTime[i]) timeD[i*DATA_W +: DATA_W] = wdata;
      if (ctrl.wrCmp[i])  cmpD[i*DATA_W +: DATA_W]  = wdata;
    end
    for (int i = 0; i < RELOAD_WORDS; i++)
      if (ctrl.wrReload[i]) reloadD[i*DATA_W +: DATA_W] = wdata;
  end

  assign match   = (cmpQ != '0) && (timeQ == cmpQ);
  assign alarmEv = match && !prevMatch;

  always_comb begin
    cntD     = cntQ;
    periodEv = 1'b0;
    if (|ctrl.wrReload)        cntD = reloadD;
    else if (reloadQ == '0)    cntD = '0;
    else if (tickEn) begin
      if (cntQ <= RELOAD_W'(1)) begin
        cntD     = reloadQ;
        periodEv = 1'b1;
      end else begin
        cntD = cntQ - RELOAD_W'(1);
      end
    end
  end

  always_comb begin
    statD[0] = alarmEv  || (statQ[0] && !(ctrl.clrStat && wdata[0]));
    statD[1] = periodEv || (statQ[1] && !(ctrl.clrStat && wdata[1]));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeQ <= '0; cmpQ <= '0; reloadQ <= '0; cntQ <= '0;
      statQ <= '0; prevMatch <= 1'b0;
    end else begin
      timeQ <= timeD; cmpQ <= cmpD; reloadQ <= reloadD; cntQ <= cntD;
      statQ <= statD; prevMatch <= match;
    end
  end

  always_comb begin
    unique case (ctrl.rdKind)
      RD_TIME:   rdData = timeQ[ctrl.rdIdx*DATA_W +: DATA_W];
      RD_CMP:    rdData = cmpQ[ctrl.rdIdx*DATA_W +: DATA_W];
      RD_RELOAD: rdData = reloadQ[ctrl.rdIdx[0]*DATA_W +: DATA_W];
      RD_COUNT:  rdData = cntQ[ctrl.rdIdx[0]*DATA_W +: DATA_W];
      RD_STAT:   rdData = DATA_W'({{(STAT_W-2){1'b0}}, statQ});
      default:   rdData = '0;
    endcase
  end

  assign alarmIrq  = statQ[0];
  assign periodIrq = statQ[1];
endmodule

// File: rtl/elapsed_rtc.sv
module elapsed_rtc
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              alarmIrq,
  output logic              periodIrq
);
  rtcCtrl_t ctrl;

  rtc_ctrl u_ctrl (
    .busSel(busSel), .busAddr(busAddr), .busWr(busWr), .ctrl(ctrl)
  );

  rtc_datapath u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .ctrl(ctrl), .wdata(busWdata),
    .rdData(rdData), .alarmIrq(alarmIrq), .periodIrq(periodIrq)
  );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
(
  input logic                           clk,
  input logic                           rstN,
  input logic                           tickEn,
  input logic                           busSel,
  input logic [ADDR_W-1:0]              busAddr,
  input logic                           busWr,
  input logic [DATA_W-1:0]              busWdata,
  input logic                           alarmIrq,
  input logic                           periodIrq,
  input logic [DATA_W*TIME_WORDS-1:0]   timeQ,
  input logic [DATA_W*TIME_WORDS-1:0]   cmpQ,
  input logic [DATA_W*RELOAD_WORDS-1:0] reloadQ,
  input logic [DATA_W*RELOAD_WORDS-1:0] cntQ
);
  logic anyTimeWr, anyReloadWr, statWr;
  assign anyTimeWr   = busWr && !busSel && (busAddr <= 5'h04);
  assign anyReloadWr = busWr && !busSel && (busAddr == 5'h10 || busAddr == 5'h12);
  assign statWr      = busWr && busSel && (busAddr == 5'h1E);

  // R2
  time_adv_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !anyTimeWr) |=> (timeQ == $past(timeQ) + 1'b1));

  // R6
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (alarmIrq && !(statWr && busWdata[0])) |=> alarmIrq);

  // R6
  period_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodIrq && !(statWr && busWdata[1])) |=> periodIrq);

  // R9
  alarm_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmpQ == '0 && !alarmIrq) |=> !alarmIrq);

  // R11
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !anyReloadWr && reloadQ != '0 && cntQ == 1) |=> (periodIrq && cntQ == reloadQ));

  // R10
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !anyReloadWr && cntQ > 1) |=> (cntQ == $past(cntQ) - 1'b1));

  // R13
  zero_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reloadQ == '0 && !anyReloadWr) |=> (cntQ == '0));
endmodule

bind elapsed_rtc rtc_chk u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busAddr(busAddr),
  .busWr(busWr), .busWdata(busWdata), .alarmIrq(alarmIrq), .periodIrq(periodIrq),
  .timeQ(u_dp.timeQ), .cmpQ(u_dp.cmpQ), .reloadQ(u_dp.reloadQ), .cntQ(u_dp.cntQ)
);

// File: tb/elapsed_rtc_bench.sv
module elapsed_rtc_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic        busSel = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWr = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] rdData;
  logic        alarmIrq, periodIrq;
  int          checks = 0;
  int          errors = 0;

  always #5 clk = ~clk;

  elapsed_rtc u_elapsed_rtc (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busSel(busSel), .busAddr(busAddr),
    .busWr(busWr), .busWdata(busWdata), .rdData(rdData),
    .alarmIrq(alarmIrq), .periodIrq(periodIrq)
  );

  // {window, offset, write data, expected readback}
  localparam int NVEC = 6;
  localparam logic [37:0] VEC [NVEC] = '{
    {1'b0, 5'h08, 16'h1357, 16'h1357},
    {1'b0, 5'h0A, 16'h2468, 16'h2468},
    {1'b0, 5'h0C, 16'hBEEF, 16'hBEEF},
    {1'b0, 5'h12, 16'h0001, 16'h0001},
    {1'b0, 5'h10, 16'h0000, 16'h0000},
    {1'b1, 5'h1E, 16'hFFFF, 16'h0000}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic win, input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = win; busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic win, input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = win; busAddr = a;
    #1 d = rdData;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic idle();
    @(negedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int a = 0; a < 32; a += 2) begin
      rd(1'b0, 5'(a), v); check("R1 window0", v, 16'h0);
    end
    rd(1'b1, 5'h1E, v); check("R1 status", v, 16'h0);
    check("R1 irqs", {14'h0, alarmIrq, periodIrq}, 16'h0);

    // R7 write/readback table
    for (int k = 0; k < NVEC; k++) begin
      wr(VEC[k][37], VEC[k][36:32], VEC[k][31:16]);
      rd(VEC[k][37], VEC[k][36:32], v);
      check("R7 readback", v, VEC[k][15:0]);
    end
    rd(1'b0, 5'h06, v); check("R7 unmapped", v, 16'h0);

    // R2 carry across all words
    wr(1'b0, 5'h00, 16'hFFFF); wr(1'b0, 5'h02, 16'hFFFF); wr(1'b0, 5'h04, 16'h0000);
    tick(1);
    rd(1'b0, 5'h00, v); check("R2 low", v, 16'h0000);
    rd(1'b0, 5'h02, v); check("R2 mid", v, 16'h0000);
    rd(1'b0, 5'h04, v); check("R2 high", v, 16'h0001);

    // R3 one-word write
    wr(1'b0, 5'h02, 16'h1234);
    rd(1'b0, 5'h00, v); check("R3 low kept", v, 16'h0000);
    rd(1'b0, 5'h04, v); check("R3 high kept", v, 16'h0001);
    rd(1'b0, 5'h02, v); check("R3 mid", v, 16'h1234);

    // R4 alarm on match
    wr(1'b0, 5'h08, 16'h0003); wr(1'b0, 5'h0A, 16'h1234); wr(1'b0, 5'h0C, 16'h0001);
    tick(2); idle();
    check("R4 before match", {15'h0, alarmIrq}, 16'h0);
    tick(1); idle();
    check("R4 at match", {15'h0, alarmIrq}, 16'h1);
    tick(1); idle();
    check("R6 sticky", {15'h0, alarmIrq}, 16'h1);
    rd(1'b1, 5'h1E, v); check("R7 status alarm", v, 16'h0001);
    wr(1'b1, 5'h1E, 16'h0002);
    check("R8 other bit", {15'h0, alarmIrq}, 16'h1);
    wr(1'b1, 5'h1E, 16'h0001);
    check("R8 clear", {15'h0, alarmIrq}, 16'h0);

    // R5 held match fires once
    wr(1'b0, 5'h00, 16'h0003); idle();
    check("R5 rematch", {15'h0, alarmIrq}, 16'h1);
    wr(1'b1, 5'h1E, 16'h0001); idle(); idle();
    check("R5 no refire", {15'h0, alarmIrq}, 16'h0);

    // R9 zero compare inactive
    wr(1'b0, 5'h08, 16'h0); wr(1'b0, 5'h0A, 16'h0); wr(1'b0, 5'h0C, 16'h0);
    wr(1'b0, 5'h00, 16'h0); wr(1'b0, 5'h02, 16'h0); wr(1'b0, 5'h04, 16'h0);
    idle(); idle();
    check("R9 zero compare", {15'h0, alarmIrq}, 16'h0);

    // R10 / R11 periodic with reload 5
    wr(1'b0, 5'h12, 16'h0000); wr(1'b0, 5'h10, 16'h0005);
    rd(1'b0, 5'h14, v); check("R10 load", v, 16'h0005);
    tick(4);
    rd(1'b0, 5'h14, v); check("R10 count", v, 16'h0001);
    check("R10 early", {15'h0, periodIrq}, 16'h0);
    tick(1);
    check("R11 event", {15'h0, periodIrq}, 16'h1);
    rd(1'b0, 5'h14, v); check("R11 reload", v, 16'h0005);
    rd(1'b1, 5'h1E, v); check("R7 status period", v, 16'h0002);

    // R12 clear and event in the same cycle
    tick(4);
    @(negedge clk);
    tickEn = 1'b1; busSel = 1'b1; busAddr = 5'h1E; busWdata = 16'h0002; busWr = 1'b1;
    @(negedge clk);
    tickEn = 1'b0; busWr = 1'b0;
    check("R12 event wins", {15'h0, periodIrq}, 16'h1);
    wr(1'b1, 5'h1E, 16'h0002);
    check("R8 period clear", {15'h0, periodIrq}, 16'h0);

    // R13 zero reload stops
    wr(1'b0, 5'h10, 16'h0000);
    tick(10);
    rd(1'b0, 5'h14, v); check("R13 count", v, 16'h0000);
    check("R13 no event", {15'h0, periodIrq}, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule